// File: doc/BRIEF.md
# Block-Sampled Correlation Address Sequencer

This block drives the memories of a block-sampled correlation engine. Input samples live in a circular buffer whose length is a power of two; one period of sine and cosine reference values lives in two small tables that share one address. On each block start the sequencer first emits write addresses for the incoming samples. It then emits one read pair per multiply-accumulate: a sample address and a reference address for every tap of every output of the block. Memories, multipliers and accumulators sit outside.

The first block primes the storage: it writes every sample the first window set needs, and it fills the reference tables with one period. Later blocks write only the block's new samples, each over the oldest entry. The reference tables are not written again. At the end of each block the sample pointer advances by the block length modulo the buffer length, and the reference pointer advances by the block length modulo the reference period. Because the two moduli differ, the sample and reference addresses of a pair drift apart from block to block.

Parameters: block length `BLK_LEN` (B), correlation length `CORR_LEN` (L), sample buffer length `BUF_LEN` (S, a power of two, at least B+L-1), reference period `REF_PERIOD` (P) and reference table depth `REF_DEPTH` (at least P). In the defaults B=4, L=5, S=8, P=5 and the depth is 8. Block k then reads samples k·4 to k·4+7.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, and whenever no block is in progress, `smp_we_o`, `ref_we_o`, `pair_vld_o` and `blk_done_o` are low.
- R2: When `blk_start_i` is sampled high in the first block after reset, a load phase of max(B+L-1, P) cycles begins on the next cycle. In load cycle w the sample write strobe is high for w < B+L-1 with `smp_waddr_o` = w, and the reference write strobe is high for w < P with `ref_waddr_o` = w.
- R3: In every later block the load phase lasts B cycles. In cycle w the sample write strobe is high with `smp_waddr_o` = (ptr + L-1 + w) mod S, which is the oldest entry, and `ref_we_o` stays low.
- R4: The read phase follows the load phase directly and lasts B·L cycles with `pair_vld_o` high. Output j runs from 0 to B-1 in the outer order and tap i from 0 to L-1 in the inner order. Each pair gives `smp_raddr_o` = (ptr + j + i) mod S and `ref_raddr_o` = (rptr + j + i) mod P. Block k reads samples X(4k) to X(4k+7) in the default configuration.
- R5: ptr starts at 0 and advances by (ptr + B) mod S at the end of each block.
- R6: rptr starts at 0 and advances by (rptr + B) mod P at the end of each block.
- R7: `blk_done_o` is high for exactly the one cycle after the last pair of a block.
- R8: `blk_start_i` is ignored while a block is in progress, including its done cycle. Such a start neither restarts the sequence nor advances a pointer.
- R9: `pair_vld_o` is never high in the same cycle as either write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_start_i | input | 1 | Start one block period |
| smp_we_o | output | 1 | Sample buffer write strobe |
| smp_waddr_o | output | $clog2(BUF_LEN) | Sample buffer write address |
| ref_we_o | output | 1 | Sine/cosine table write strobe |
| ref_waddr_o | output | $clog2(REF_DEPTH) | Sine/cosine table write address |
| pair_vld_o | output | 1 | One multiply pair is addressed this cycle |
| smp_raddr_o | output | $clog2(BUF_LEN) | Sample buffer read address |
| ref_raddr_o | output | $clog2(REF_DEPTH) | Sine/cosine table read address |
| blk_done_o | output | 1 | Block sequence complete |

## Verification
The bench uses the defaults B=4, L=5, S=8 and P=5. With these values the window span equals the buffer length, so the priming block fills the whole buffer. Running six consecutive blocks takes the reference pointer through every residue 0, 4, 3, 2, 1 and back to 0, while the sample pointer alternates between 0 and 4. This exercises both wrap paths and the drift between the two address streams. Start pulses injected during the read phase and during the done cycle check that the sequence continues and no pointer moves.

// File: rtl/circ_pkg.sv
package circ_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/circ_seq.sv
module circ_seq
  import circ_pkg::*;
#(
  parameter int BLK_LEN    = 4,
  parameter int CORR_LEN   = 5,
  parameter int REF_PERIOD = 5,
  localparam int SPAN      = BLK_LEN + CORR_LEN - 1,
  localparam int PRIME     = (SPAN > REF_PERIOD) ? SPAN : REF_PERIOD,
  localparam int WCW       = $clog2(PRIME + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output seq_st_e        st_o,
  output logic           first_o,
  output logic [WCW-1:0] wr_idx_o,
  output logic           smp_we_o,
  output logic           ref_we_o,
  output logic           run_load_o,
  output logic           row_end_o,
  output logic           advance_o
);
  localparam int IW = $clog2(CORR_LEN + 1);
  localparam int JW = $clog2(BLK_LEN + 1);

  seq_st_e        st_q;
  logic           first_q;
  logic [WCW-1:0] w_q;
  logic [IW-1:0]  i_q;
  logic [JW-1:0]  j_q;
  logic           load_last, i_last, j_last;

  assign load_last = first_q ? (w_q == WCW'(PRIME - 1)) : (w_q == WCW'(BLK_LEN - 1));
  assign i_last    = (i_q == IW'(CORR_LEN - 1));
  assign j_last    = (j_q == JW'(BLK_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b1;
      w_q     <= '0;
      i_q     <= '0;
      j_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_LOAD;
          w_q  <= '0;
        end
        ST_LOAD: begin
          w_q <= w_q + 1'b1;
          if (load_last) begin
            st_q <= ST_RUN;
            i_q  <= '0;
            j_q  <= '0;
          end
        end
        ST_RUN: begin
          if (i_last) begin
            i_q <= '0;
            if (j_last) st_q <= ST_DONE;
            else        j_q  <= j_q + 1'b1;
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        ST_DONE: begin
          st_q    <= ST_IDLE;
          first_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign first_o    = first_q;
  assign wr_idx_o   = w_q;
  assign smp_we_o   = (st_q == ST_LOAD) &&
                      (first_q ? (w_q < WCW'(SPAN)) : (w_q < WCW'(BLK_LEN)));
  assign ref_we_o   = (st_q == ST_LOAD) && first_q && (w_q < WCW'(REF_PERIOD));
  assign run_load_o = (st_q == ST_LOAD) && load_last;
  assign row_end_o  = (st_q == ST_RUN) && i_last;
  assign advance_o  = (st_q == ST_DONE);
endmodule

// File: rtl/circ_ptr.sv
module circ_ptr #(
  parameter int BLK_LEN    = 4,
  parameter int BUF_LEN    = 8,
  parameter int REF_PERIOD = 5,
  parameter int REF_DEPTH  = 8,
  localparam int SW        = $clog2(BUF_LEN),
  localparam int RW        = $clog2(REF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_load_i,
  input  logic          step_i,
  input  logic          row_end_i,
  input  logic          advance_i,
  output logic [SW-1:0] ptr_o,
  output logic [SW-1:0] s_acc_o,
  output logic [RW-1:0] r_acc_o
);
  localparam int RSTEP = BLK_LEN % REF_PERIOD;

  logic [SW-1:0] ptr_q, s_row_q, s_acc_q;
  logic [RW-1:0] rptr_q, r_row_q, r_acc_q;
  logic [RW-1:0] r_row_inc, r_acc_inc, rptr_adv;

  // reference wrap: free-running when period fills the table, compare otherwise
  if (REF_PERIOD == (1 << RW)) begin : g_ref_pow2
    assign r_row_inc = r_row_q + 1'b1;
    assign r_acc_inc = r_acc_q + 1'b1;
    assign rptr_adv  = rptr_q + RW'(RSTEP);
  end else begin : g_ref_mod
    logic [RW:0] adv_sum;
    assign r_row_inc = (r_row_q == RW'(REF_PERIOD - 1)) ? '0 : r_row_q + 1'b1;
    assign r_acc_inc = (r_acc_q == RW'(REF_PERIOD - 1)) ? '0 : r_acc_q + 1'b1;
    assign adv_sum   = {1'b0, rptr_q} + (RW + 1)'(RSTEP);
    assign rptr_adv  = (adv_sum >= (RW + 1)'(REF_PERIOD)) ?
                       RW'(adv_sum - (RW + 1)'(REF_PERIOD)) : adv_sum[RW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      s_row_q <= '0;
      s_acc_q <= '0;
      rptr_q  <= '0;
      r_row_q <= '0;
      r_acc_q <= '0;
    end else begin
      if (run_load_i) begin
        s_row_q <= ptr_q;
        s_acc_q <= ptr_q;
        r_row_q <= rptr_q;
        r_acc_q <= rptr_q;
      end else if (step_i) begin
        if (row_end_i) begin
          s_row_q <= s_row_q + 1'b1;
          s_acc_q <= s_row_q + 1'b1;
          r_row_q <= r_row_inc;
          r_acc_q <= r_row_inc;
        end else begin
          s_acc_q <= s_acc_q + 1'b1;
          r_acc_q <= r_acc_inc;
        end
      end
      if (advance_i) begin
        ptr_q  <= ptr_q + SW'(BLK_LEN % BUF_LEN);
        rptr_q <= rptr_adv;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign s_acc_o = s_acc_q;
  assign r_acc_o = r_acc_q;
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import circ_pkg::*;
#(
  parameter int BLK_LEN    = 4,
  parameter int CORR_LEN   = 5,
  parameter int BUF_LEN    = 8,
  parameter int REF_PERIOD = 5,
  parameter int REF_DEPTH  = 8,
  localparam int SW        = $clog2(BUF_LEN),
  localparam int RW        = $clog2(REF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_start_i,
  output logic          smp_we_o,
  output logic [SW-1:0] smp_waddr_o,
  output logic          ref_we_o,
  output logic [RW-1:0] ref_waddr_o,
  output logic          pair_vld_o,
  output logic [SW-1:0] smp_raddr_o,
  output logic [RW-1:0] ref_raddr_o,
  output logic          blk_done_o
);
  localparam int SPAN  = BLK_LEN + CORR_LEN - 1;
  localparam int PRIME = (SPAN > REF_PERIOD) ? SPAN : REF_PERIOD;
  localparam int WCW   = $clog2(PRIME + 1);

  seq_st_e        st;
  logic           first, run_load, row_end, advance;
  logic [WCW-1:0] wr_idx;
  logic [SW-1:0]  ptr;

  circ_seq #(
    .BLK_LEN   (BLK_LEN),
    .CORR_LEN  (CORR_LEN),
    .REF_PERIOD(REF_PERIOD)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (blk_start_i),
    .st_o      (st),
    .first_o   (first),
    .wr_idx_o  (wr_idx),
    .smp_we_o  (smp_we_o),
    .ref_we_o  (ref_we_o),
    .run_load_o(run_load),
    .row_end_o (row_end),
    .advance_o (advance)
  );

  circ_ptr #(
    .BLK_LEN   (BLK_LEN),
    .BUF_LEN   (BUF_LEN),
    .REF_PERIOD(REF_PERIOD),
    .REF_DEPTH (REF_DEPTH)
  ) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_load_i(run_load),
    .step_i    (pair_vld_o),
    .row_end_i (row_end),
    .advance_i (advance),
    .ptr_o     (ptr),
    .s_acc_o   (smp_raddr_o),
    .r_acc_o   (ref_raddr_o)
  );

  // new samples land just past the previous window, i.e. on the oldest slots
  assign smp_waddr_o = first ? SW'(wr_idx)
                             : SW'(int'(ptr) + CORR_LEN - 1 + int'(wr_idx));
  assign ref_waddr_o = RW'(wr_idx);
  assign pair_vld_o  = (st == ST_RUN);
  assign blk_done_o  = advance;
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int BLK_LEN    = 4,
  parameter int CORR_LEN   = 5,
  parameter int BUF_LEN    = 8,
  parameter int REF_PERIOD = 5,
  parameter int REF_DEPTH  = 8,
  localparam int SW        = $clog2(BUF_LEN),
  localparam int RW        = $clog2(REF_DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blk_start_i,
  input logic          smp_we_o,
  input logic [SW-1:0] smp_waddr_o,
  input logic          ref_we_o,
  input logic [RW-1:0] ref_waddr_o,
  input logic          pair_vld_o,
  input logic [SW-1:0] smp_raddr_o,
  input logic [RW-1:0] ref_raddr_o,
  input logic          blk_done_o
);
  logic          prev_vld;
  logic [SW-1:0] prev_sa;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld <= 1'b0;
      prev_sa  <= '0;
    end else begin
      prev_vld <= pair_vld_o;
      prev_sa  <= smp_raddr_o;
    end
  end

  // R9
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> !(smp_we_o || ref_we_o));

  // R7
  done_after_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |-> prev_vld);

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |=> !blk_done_o);

  // R4
  run_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |=> (pair_vld_o || blk_done_o));

  // R4
  ref_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> (int'(ref_raddr_o) < REF_PERIOD));

  // R4
  smp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_vld_o && prev_vld) |->
      ((smp_raddr_o == SW'(int'(prev_sa) + 1)) ||
       (smp_raddr_o == SW'(int'(prev_sa) + 2 - CORR_LEN))));

  // R8
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |=> !(smp_we_o || ref_we_o || pair_vld_o));

  // R2
  ref_wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_we_o |-> (int'(ref_waddr_o) < REF_PERIOD));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(
  .BLK_LEN   (BLK_LEN),
  .CORR_LEN  (CORR_LEN),
  .BUF_LEN   (BUF_LEN),
  .REF_PERIOD(REF_PERIOD),
  .REF_DEPTH (REF_DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .blk_start_i(blk_start_i),
  .smp_we_o   (smp_we_o),
  .smp_waddr_o(smp_waddr_o),
  .ref_we_o   (ref_we_o),
  .ref_waddr_o(ref_waddr_o),
  .pair_vld_o (pair_vld_o),
  .smp_raddr_o(smp_raddr_o),
  .ref_raddr_o(ref_raddr_o),
  .blk_done_o (blk_done_o)
);

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb;
  localparam int B = 4, L = 5, S = 8, P = 5, RD = 8;
  localparam int SW = $clog2(S), RW = $clog2(RD);
  localparam int SPAN = B + L - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic smp_we, ref_we, pair_vld, done;
  logic [SW-1:0] smp_waddr, smp_raddr;
  logic [RW-1:0] ref_waddr, ref_raddr;

  always #2 clk = ~clk;

  circ_addr_gen #(.BLK_LEN(B), .CORR_LEN(L), .BUF_LEN(S), .REF_PERIOD(P), .REF_DEPTH(RD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .blk_start_i(start),
    .smp_we_o(smp_we), .smp_waddr_o(smp_waddr), .ref_we_o(ref_we), .ref_waddr_o(ref_waddr),
    .pair_vld_o(pair_vld), .smp_raddr_o(smp_raddr), .ref_raddr_o(ref_raddr), .blk_done_o(done));

  int n_chk = 0, n_fail = 0;
  int m_ptr = 0, m_rptr = 0;
  bit m_first = 1'b1;
  int first_sa, last_sa, first_ra;
  int e_swe[$], e_swa[$], e_rwe[$], e_rwa[$], e_pv[$], e_sa[$], e_ra[$], e_dn[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int swe, swa, rwe, rwa, pv, sa, ra, dn);
    e_swe.push_back(swe); e_swa.push_back(swa); e_rwe.push_back(rwe); e_rwa.push_back(rwa);
    e_pv.push_back(pv); e_sa.push_back(sa); e_ra.push_back(ra); e_dn.push_back(dn);
  endtask

  task automatic build();
    int load_n;
    e_swe.delete(); e_swa.delete(); e_rwe.delete(); e_rwa.delete();
    e_pv.delete(); e_sa.delete(); e_ra.delete(); e_dn.delete();
    load_n = m_first ? ((SPAN > P) ? SPAN : P) : B;
    for (int w = 0; w < load_n; w++) begin
      if (m_first) push(w < SPAN, w, w < P, w, 0, 0, 0, 0);
      else         push(1, (m_ptr + L - 1 + w) % S, 0, 0, 0, 0, 0, 0);
    end
    for (int j = 0; j < B; j++)
      for (int i = 0; i < L; i++)
        push(0, 0, 0, 0, 1, (m_ptr + j + i) % S, (m_rptr + j + i) % P, 0);
    push(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic check_idle(input string req);
    chk(!smp_we && !ref_we && !pair_vld && !done, req,
        {smp_we, ref_we, pair_vld, done}, 0);
  endtask

  task automatic cmp(input int n);
    string wreq;
    wreq = m_first ? "R2" : "R3";
    chk(smp_we == e_swe[n], wreq, smp_we, e_swe[n]);
    if (e_swe[n] != 0) chk(int'(smp_waddr) == e_swa[n], wreq, smp_waddr, e_swa[n]);
    chk(ref_we == e_rwe[n], "R2/R3 ref strobe", ref_we, e_rwe[n]);
    if (e_rwe[n] != 0) chk(int'(ref_waddr) == e_rwa[n], "R2", ref_waddr, e_rwa[n]);
    chk(pair_vld == e_pv[n], "R4", pair_vld, e_pv[n]);
    if (e_pv[n] != 0) begin
      chk(int'(smp_raddr) == e_sa[n], "R4 sample", smp_raddr, e_sa[n]);
      chk(int'(ref_raddr) == e_ra[n], "R4 ref", ref_raddr, e_ra[n]);
    end
    chk(done == e_dn[n], "R7", done, e_dn[n]);
    chk(!(pair_vld && (smp_we || ref_we)), "R9", {pair_vld, smp_we, ref_we}, 0);
  endtask

  // Called at a negedge; returns at a negedge with the block fully checked.
  task automatic run_block(input bit poke_run, input bit poke_done);
    int first_pair;
    build();
    first_pair = -1;
    start = 1'b1;
    @(negedge clk);
    for (int n = 0; n < e_pv.size(); n++) begin
      cmp(n);
      if (e_pv[n] != 0) begin
        if (first_pair < 0) begin
          first_pair = n;
          first_sa = smp_raddr;
          first_ra = ref_raddr;
        end
        last_sa = smp_raddr;
      end
      start = (poke_run && e_pv[n] != 0 && n == first_pair + 3) ||
              (poke_done && e_dn[n] != 0);
      @(negedge clk);
    end
    start = 1'b0;
    check_idle(poke_done ? "R8 start in done cycle" : "R1 idle after block");
    // R5 R6 model update
    m_ptr   = (m_ptr + B) % S;
    m_rptr  = (m_rptr + B) % P;
    m_first = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    check_idle("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_idle("R1 after reset");
    @(negedge clk);
    check_idle("R1 idle");

    run_block(1'b0, 1'b0);                        // block 0: prime
    chk(first_sa == 0, "R4 block0 first X", first_sa, 0);
    chk(last_sa == 7, "R4 block0 last X", last_sa, 7);

    run_block(1'b0, 1'b0);                        // block 1
    chk(first_sa == 4, "R5 block1 ptr", first_sa, 4);
    chk(last_sa == 3, "R4 block1 last X(11)", last_sa, 3);
    chk(first_ra == 4, "R6 block1 rptr", first_ra, 4);

    run_block(1'b1, 1'b1);                        // block 2 with ignored starts
    chk(first_sa == 0, "R5 block2 ptr", first_sa, 0);
    chk(first_ra == 3, "R6 block2 rptr wrap", first_ra, 3);

    repeat (2) @(negedge clk);
    check_idle("R8 no restart");
    run_block(1'b0, 1'b0);                        // block 3
    chk(first_sa == 4, "R8 single advance ptr", first_sa, 4);
    chk(first_ra == 2, "R8 single advance rptr", first_ra, 2);

    run_block(1'b0, 1'b1);                        // block 4
    chk(first_ra == 1, "R6 block4 rptr", first_ra, 1);
    run_block(1'b0, 1'b0);                        // block 5
    chk(first_ra == 0, "R6 block5 rptr back to 0", first_ra, 0);
    chk(first_sa == 4, "R5 block5 ptr", first_sa, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule